// File: doc/BRIEF.md
# Iterative Multi-Pass Multiply Unit

This block is the multiply stage of a processor's execute pipeline. It owns one signed 33x17 multiplier array. It builds products as wide as 32x32 to 64 bits by sending the operands through that array over several clock passes. The number of passes depends on the operation class, and on whether the operation updates the condition flags. While passes remain, the unit holds the execute slot and raises `busy`, so the issue logic must not present a new operation.

An operation is launched by a one-cycle `start` with a class code, two 32-bit sources, a 64-bit accumulator and a set-flags bit. Results come back on registered one-cycle strobes: one for the low 32-bit word, one for the high word of 64-bit forms, and one for the N/Z flags. The high word always follows the low word by one cycle. Register file access, forwarding and decode belong to the surrounding pipeline.

Top module: `imul_unit`

## Requirements
- R1: While reset is held and right after it is released, `busy`, `res_lo_valid`, `res_hi_valid` and `flags_valid` are low.
- R2: Class codes and results (a = `src_a`, b = `src_b`, c = `acc_in`). Code 0: a[15:0]*b[15:0], signed. Code 1: bits 47..16 of a*b[15:0], signed. Code 2: code 0 result + c[31:0]. Code 3: code 1 result + c[31:0]. Code 4: low 32 bits of a*b. Code 5: low 32 bits of a*b+c. Code 6: unsigned a*b to 64 bits. Code 7: signed a*b to 64 bits. Code 8: code 6 + c. Code 9: code 7 + c. 64-bit forms are codes 6 to 9.
- R3: Counting clock edges from the edge that samples an accepted `start` as edge 0, `busy` is high from edge 0 until edge P, where P is the pass count given in R4 to R8.
- R4: Codes 0 and 1 use P=1. Codes 2 and 3 use P=2. For all four codes the low-word strobe follows edge 2, and `set_flags` has no effect on them.
- R5: Codes 4 and 5 without flag update use P=2, with the low-word strobe after edge 3.
- R6: Codes 4 and 5 with flag update use P=4, with the low-word strobe after edge 3 and the flags strobe after edge 4.
- R7: Codes 6 to 9 without flag update use P=3, with the low word after edge 4 and the high word after edge 5.
- R8: Codes 6 to 9 with flag update use P=5, with the low word after edge 4 and the high word and flags after edge 5.
- R9: Flags: N is bit 63 of a 64-bit result or bit 31 of a 32-bit result, and Z is set when that result is all zero. Codes 0 to 3 never raise `flags_valid`.
- R10: A `start` sampled while `busy` is high is ignored. The running operation's results and timing are unchanged, and no extra strobe appears.
- R11: A `start` carrying a code from 10 to 15 is ignored. `busy` stays low and no strobe appears.
- R12: A new operation may start on the first edge after `busy` falls, while the previous operation is still delivering its words. Both sets of results arrive intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch request, sampled when `busy` is low |
| op_code | input | 4 | Operation class code (R2) |
| set_flags | input | 1 | Request flag update for codes 4 to 9 |
| src_a | input | 32 | First source operand |
| src_b | input | 32 | Second source operand |
| acc_in | input | 64 | Accumulator addend |
| busy | output | 1 | Passes remain, so the execute slot is held |
| res_lo_valid | output | 1 | One-cycle strobe for `res_lo` |
| res_lo | output | 32 | Low result word |
| res_hi_valid | output | 1 | One-cycle strobe for `res_hi` |
| res_hi | output | 32 | High result word of 64-bit forms |
| flags_valid | output | 1 | One-cycle strobe for the flags |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |

## Verification
Every class is driven with operands at the signed extremes. The most negative 16-bit and 32-bit values squared separate a correct sign extension in the array from a zero-extended one, and all-ones unsigned operands separate the unsigned long forms from the signed ones. The accumulating forms get accumulators chosen to cancel the product exactly, so the Z flag and the accumulate pass are seen to act in the right pass. The same classes with and without set-flags separate the pass counts and the delivery cycles. A second start during busy, a reserved code, and a start on the first free edge after a long multiply separate correct acceptance from a lost or doubled operation.

// File: rtl/imul_pkg.sv
package imul_pkg;

  localparam int unsigned WORD_W  = 32;
  localparam int unsigned HALF_W  = WORD_W / 2;
  localparam int unsigned DWORD_W = 2 * WORD_W;
  localparam int unsigned X_W     = WORD_W + 1;
  localparam int unsigned Y_W     = HALF_W + 1;
  localparam int unsigned PP_W    = X_W + Y_W;
  localparam int unsigned PASS_W  = 3;
  localparam int unsigned CODE_W  = 4;
  localparam logic [CODE_W-1:0] LAST_CODE = 4'd9;

  typedef enum logic [CODE_W-1:0] {
    OP_SMUL16 = 4'd0,
    OP_SMULWH = 4'd1,
    OP_SMLA16 = 4'd2,
    OP_SMLAWH = 4'd3,
    OP_MUL    = 4'd4,
    OP_MLA    = 4'd5,
    OP_UMULL  = 4'd6,
    OP_SMULL  = 4'd7,
    OP_UMLAL  = 4'd8,
    OP_SMLAL  = 4'd9
  } op_e;

  typedef struct packed {
    logic [X_W-1:0] x;
    logic [Y_W-1:0] y;
  } arr_in_t;

  function automatic logic op_known(logic [CODE_W-1:0] c);
    return c <= LAST_CODE;
  endfunction

  function automatic logic op_long(op_e o);
    return o inside {OP_UMULL, OP_SMULL, OP_UMLAL, OP_SMLAL};
  endfunction

  function automatic logic op_sets_flags(op_e o, logic sf);
    return sf && (op_long(o) || o inside {OP_MUL, OP_MLA});
  endfunction

  function automatic logic [PASS_W-1:0] value_passes(op_e o);
    case (o)
      OP_SMUL16, OP_SMULWH:                   return PASS_W'(1);
      OP_SMLA16, OP_SMLAWH, OP_MUL, OP_MLA:   return PASS_W'(2);
      default:                                return PASS_W'(3);
    endcase
  endfunction

  // Flag forms add a settle pass and a flag pass after the value passes.
  function automatic logic [PASS_W-1:0] pass_total(op_e o, logic sf);
    return value_passes(o) + (op_sets_flags(o, sf) ? PASS_W'(2) : PASS_W'(0));
  endfunction

  // Edge (counted from the accepting edge) on which the low word is registered.
  function automatic logic [PASS_W-1:0] lo_edge(op_e o, logic sf);
    if (op_sets_flags(o, sf))             return pass_total(o, sf) - PASS_W'(1);
    else if (o inside {OP_SMLA16, OP_SMLAWH}) return pass_total(o, sf);
    else                                  return pass_total(o, sf) + PASS_W'(1);
  endfunction

  function automatic arr_in_t array_operands(op_e o, logic [WORD_W-1:0] a,
                                             logic [WORD_W-1:0] b, logic upper);
    arr_in_t r;
    logic [HALF_W-1:0] bh;
    bh = upper ? b[WORD_W-1:HALF_W] : b[HALF_W-1:0];
    case (o)
      OP_SMUL16, OP_SMLA16: begin
        r.x = {{(X_W-HALF_W){a[HALF_W-1]}}, a[HALF_W-1:0]};
        r.y = {bh[HALF_W-1], bh};
      end
      OP_SMULWH, OP_SMLAWH: begin
        r.x = {a[WORD_W-1], a};
        r.y = {bh[HALF_W-1], bh};
      end
      OP_SMULL, OP_SMLAL: begin
        r.x = {a[WORD_W-1], a};
        r.y = upper ? {bh[HALF_W-1], bh} : {1'b0, bh};
      end
      default: begin
        r.x = {1'b0, a};
        r.y = {1'b0, bh};
      end
    endcase
    return r;
  endfunction

  function automatic logic [PP_W-1:0] array_mul(logic [X_W-1:0] x, logic [Y_W-1:0] y);
    logic signed [PP_W-1:0] p;
    p = $signed(x) * $signed(y);
    return $unsigned(p);
  endfunction

  // Widen the array output; the word-by-halfword forms keep bits 47..16.
  function automatic logic [DWORD_W-1:0] scale_product(op_e o, logic [PP_W-1:0] pp);
    if (o inside {OP_SMULWH, OP_SMLAWH})
      return {{(DWORD_W-WORD_W){pp[HALF_W+WORD_W-1]}}, pp[HALF_W +: WORD_W]};
    else
      return {{(DWORD_W-PP_W){pp[PP_W-1]}}, pp};
  endfunction

  function automatic logic [DWORD_W-1:0] pass_step(op_e o, logic [PASS_W-1:0] k,
                                                   logic [DWORD_W-1:0] sum,
                                                   logic [DWORD_W-1:0] pp_ext,
                                                   logic [DWORD_W-1:0] acc);
    logic [DWORD_W-1:0] hi_term;
    hi_term = pp_ext << HALF_W;
    case (k)
      PASS_W'(0): return pp_ext;
      PASS_W'(1): begin
        case (o)
          OP_SMLA16, OP_SMLAWH:               return sum + acc;
          OP_MLA:                             return sum + hi_term + acc;
          OP_MUL, OP_UMULL, OP_SMULL,
          OP_UMLAL, OP_SMLAL:                 return sum + hi_term;
          default:                            return sum;
        endcase
      end
      PASS_W'(2): return (o inside {OP_UMLAL, OP_SMLAL}) ? sum + acc : sum;
      default:    return sum;
    endcase
  endfunction

  // Returns {N, Z}.
  function automatic logic [1:0] nz_of(logic [DWORD_W-1:0] v, logic is_long);
    if (is_long) return {v[DWORD_W-1], v == '0};
    else         return {v[WORD_W-1], v[WORD_W-1:0] == '0};
  endfunction

endpackage

// File: rtl/imul_pass_ctrl.sv
module imul_pass_ctrl
  import imul_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CODE_W-1:0] op_code,
  input  logic              set_flags,
  output logic              busy,
  output op_e               op_q,
  output logic              load,
  output logic              step,
  output logic [PASS_W-1:0] pass_idx,
  output logic              evt_lo_now,
  output logic              evt_lo_tail,
  output logic              evt_flags
);

  logic              busy_q;
  logic              sf_q;
  logic              tail_q;
  logic [PASS_W-1:0] cnt_q;
  logic [PASS_W-1:0] total;
  logic [PASS_W-1:0] lo_at;
  logic              accept;
  logic              last_pass;

  assign total     = pass_total(op_q, sf_q);
  assign lo_at     = lo_edge(op_q, sf_q);
  assign accept    = start && !busy_q && op_known(op_code);
  assign last_pass = busy_q && (cnt_q == total);

  assign busy        = busy_q;
  assign load        = accept;
  assign step        = busy_q;
  assign pass_idx    = cnt_q - PASS_W'(1);
  assign evt_lo_now  = busy_q && (cnt_q == lo_at);
  assign evt_lo_tail = tail_q && (lo_at == total + PASS_W'(1));
  assign evt_flags   = last_pass && op_sets_flags(op_q, sf_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      sf_q   <= 1'b0;
      tail_q <= 1'b0;
      cnt_q  <= '0;
      op_q   <= OP_SMUL16;
    end else begin
      tail_q <= last_pass;
      if (accept) begin
        busy_q <= 1'b1;
        cnt_q  <= PASS_W'(1);
        op_q   <= op_e'(op_code);
        sf_q   <= set_flags;
      end else if (busy_q) begin
        if (last_pass) busy_q <= 1'b0;
        else           cnt_q  <= cnt_q + PASS_W'(1);
      end
    end
  end

  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && start |=> $stable(op_q) && $stable(sf_q)); // R10
  AST_BUSY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && (cnt_q < total) |=> busy_q); // R3
  AST_RESERVED_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy_q && !op_known(op_code) |=> !busy_q); // R11

endmodule

// File: rtl/imul_datapath.sv
module imul_datapath
  import imul_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic               step,
  input  op_e                op,
  input  logic [PASS_W-1:0]  pass_idx,
  input  logic [WORD_W-1:0]  a_in,
  input  logic [WORD_W-1:0]  b_in,
  input  logic [DWORD_W-1:0] acc_in,
  output logic [DWORD_W-1:0] sum_q,
  output logic [DWORD_W-1:0] sum_next
);

  logic [WORD_W-1:0]  a_q;
  logic [WORD_W-1:0]  b_q;
  logic [DWORD_W-1:0] acc_q;
  arr_in_t            opnd;
  logic [PP_W-1:0]    pp;
  logic [DWORD_W-1:0] pp_ext;

  always_comb begin
    opnd     = array_operands(op, a_q, b_q, pass_idx == PASS_W'(1));
    pp       = array_mul(opnd.x, opnd.y);
    pp_ext   = scale_product(op, pp);
    sum_next = pass_step(op, pass_idx, sum_q, pp_ext, acc_q);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_q   <= '0;
      b_q   <= '0;
      acc_q <= '0;
      sum_q <= '0;
    end else begin
      if (load) begin
        a_q   <= a_in;
        b_q   <= b_in;
        acc_q <= acc_in;
      end
      if (step) sum_q <= sum_next;
    end
  end

  AST_ZERO_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    step && (pass_idx == PASS_W'(0)) && (b_q == '0) |=> sum_q == '0); // R2

endmodule

// File: rtl/imul_deliver.sv
module imul_deliver
  import imul_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               evt_lo_now,
  input  logic               evt_lo_tail,
  input  logic               evt_flags,
  input  logic               is_long,
  input  logic [DWORD_W-1:0] sum_q,
  input  logic [DWORD_W-1:0] sum_next,
  output logic               res_lo_valid,
  output logic [WORD_W-1:0]  res_lo,
  output logic               res_hi_valid,
  output logic [WORD_W-1:0]  res_hi,
  output logic               flags_valid,
  output logic               flag_n,
  output logic               flag_z
);

  logic               fire_lo;
  logic [DWORD_W-1:0] pick;
  logic [1:0]         nz;
  logic               hi_pend_q;
  logic [WORD_W-1:0]  hi_hold_q;

  assign fire_lo = evt_lo_now || evt_lo_tail;
  assign pick    = evt_lo_now ? sum_next : sum_q;
  assign nz      = nz_of(sum_next, is_long);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_lo_valid <= 1'b0;
      res_lo       <= '0;
      res_hi_valid <= 1'b0;
      res_hi       <= '0;
      flags_valid  <= 1'b0;
      flag_n       <= 1'b0;
      flag_z       <= 1'b0;
      hi_pend_q    <= 1'b0;
      hi_hold_q    <= '0;
    end else begin
      res_lo_valid <= fire_lo;
      hi_pend_q    <= fire_lo && is_long;
      res_hi_valid <= hi_pend_q;
      flags_valid  <= evt_flags;
      if (fire_lo) begin
        res_lo    <= pick[WORD_W-1:0];
        hi_hold_q <= pick[DWORD_W-1:WORD_W];
      end
      if (hi_pend_q) res_hi <= hi_hold_q;
      if (evt_flags) {flag_n, flag_z} <= nz;
    end
  end

  AST_HI_AFTER_LO: assert property (@(posedge clk) disable iff (!rst_n)
    res_hi_valid |-> $past(res_lo_valid)); // R7
  AST_FLAGS_APART: assert property (@(posedge clk) disable iff (!rst_n)
    flags_valid |-> !res_lo_valid); // R6
  AST_WORDS_APART: assert property (@(posedge clk) disable iff (!rst_n)
    res_lo_valid |-> !res_hi_valid); // R12

endmodule

// File: rtl/imul_unit.sv
module imul_unit
  import imul_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [3:0]  op_code,
  input  logic        set_flags,
  input  logic [31:0] src_a,
  input  logic [31:0] src_b,
  input  logic [63:0] acc_in,
  output logic        busy,
  output logic        res_lo_valid,
  output logic [31:0] res_lo,
  output logic        res_hi_valid,
  output logic [31:0] res_hi,
  output logic        flags_valid,
  output logic        flag_n,
  output logic        flag_z
);

  op_e                op_q;
  logic               load;
  logic               step;
  logic [PASS_W-1:0]  pass_idx;
  logic               evt_lo_now;
  logic               evt_lo_tail;
  logic               evt_flags;
  logic [DWORD_W-1:0] sum_q;
  logic [DWORD_W-1:0] sum_next;

  imul_pass_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .op_code     (op_code),
    .set_flags   (set_flags),
    .busy        (busy),
    .op_q        (op_q),
    .load        (load),
    .step        (step),
    .pass_idx    (pass_idx),
    .evt_lo_now  (evt_lo_now),
    .evt_lo_tail (evt_lo_tail),
    .evt_flags   (evt_flags)
  );

  imul_datapath u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .step     (step),
    .op       (op_q),
    .pass_idx (pass_idx),
    .a_in     (src_a),
    .b_in     (src_b),
    .acc_in   (acc_in),
    .sum_q    (sum_q),
    .sum_next (sum_next)
  );

  imul_deliver u_out (
    .clk          (clk),
    .rst_n        (rst_n),
    .evt_lo_now   (evt_lo_now),
    .evt_lo_tail  (evt_lo_tail),
    .evt_flags    (evt_flags),
    .is_long      (op_long(op_q)),
    .sum_q        (sum_q),
    .sum_next     (sum_next),
    .res_lo_valid (res_lo_valid),
    .res_lo       (res_lo),
    .res_hi_valid (res_hi_valid),
    .res_hi       (res_hi),
    .flags_valid  (flags_valid),
    .flag_n       (flag_n),
    .flag_z       (flag_z)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |=> !busy && !res_lo_valid && !res_hi_valid && !flags_valid); // R1

endmodule

// File: tb/imul_unit_test.sv
`timescale 1ns/1ps
module imul_unit_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  op_code = '0;
  logic        set_flags = 1'b0;
  logic [31:0] src_a = '0;
  logic [31:0] src_b = '0;
  logic [63:0] acc_in = '0;
  logic        busy, res_lo_valid, res_hi_valid, flags_valid, flag_n, flag_z;
  logic [31:0] res_lo, res_hi;

  int nchk = 0;
  int nfail = 0;

  always #10 clk = ~clk;

  imul_unit uut (
    .clk(clk), .rst_n(rst_n), .start(start), .op_code(op_code),
    .set_flags(set_flags), .src_a(src_a), .src_b(src_b), .acc_in(acc_in),
    .busy(busy), .res_lo_valid(res_lo_valid), .res_lo(res_lo),
    .res_hi_valid(res_hi_valid), .res_hi(res_hi), .flags_valid(flags_valid),
    .flag_n(flag_n), .flag_z(flag_z)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] ref_val(input int op, input logic [31:0] a,
                                          input logic [31:0] b, input logic [63:0] c);
    longint sa16, sb16, sa, sb, sc;
    longint unsigned ua, ub, uc;
    sa16 = longint'($signed(a[15:0]));
    sb16 = longint'($signed(b[15:0]));
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    sc = longint'(c);
    ua = {32'd0, a};
    ub = {32'd0, b};
    uc = c;
    case (op)
      0: return sa16 * sb16;
      1: return (sa * sb16) >>> 16;
      2: return sa16 * sb16 + sc;
      3: return ((sa * sb16) >>> 16) + sc;
      4: return ua * ub;
      5: return ua * ub + uc;
      6: return ua * ub;
      7: return sa * sb;
      8: return ua * ub + uc;
      default: return sa * sb + sc;
    endcase
  endfunction

  function automatic string tmg_tag(input int op, input bit fl);
    if (op < 4) return "R4";
    else if (op < 6) return fl ? "R6" : "R5";
    else return fl ? "R8" : "R7";
  endfunction

  // One operation; optional second start while busy (poke).
  task automatic run_op(input int op, input logic [31:0] a, input logic [31:0] b,
                        input logic [63:0] c, input bit sf, input bit poke);
    logic [63:0] e;
    bit lng, fl;
    int p, l;
    string tg;
    e = ref_val(op, a, b, c);
    lng = (op >= 6);
    fl = sf && (op >= 4);
    case (op)
      0, 1: begin p = 1; l = 2; end
      2, 3: begin p = 2; l = 2; end
      4, 5: begin p = fl ? 4 : 2; l = 3; end
      default: begin p = fl ? 5 : 3; l = 4; end
    endcase
    tg = tmg_tag(op, fl);
    @(negedge clk);
    start = 1'b1; op_code = 4'(op); src_a = a; src_b = b; acc_in = c; set_flags = sf;
    @(negedge clk);
    start = 1'b0;
    for (int t = 0; t < 8; t++) begin
      if (poke && t == 0) begin
        start = 1'b1; op_code = 4'd0; src_a = 32'h0000_0003; src_b = 32'h0000_0005;
      end
      if (poke && t == 1) start = 1'b0;
      chk(busy == (t < p), "R3", $sformatf("busy op%0d t%0d", op, t), 64'(busy), 64'(t < p));
      chk(res_lo_valid == (t == l), poke ? "R10" : tg,
          $sformatf("lo strobe op%0d t%0d", op, t), 64'(res_lo_valid), 64'(t == l));
      chk(res_hi_valid == (lng && t == l + 1), poke ? "R10" : tg,
          $sformatf("hi strobe op%0d t%0d", op, t), 64'(res_hi_valid), 64'(lng && t == l + 1));
      chk(flags_valid == (fl && t == p), "R9",
          $sformatf("flag strobe op%0d t%0d", op, t), 64'(flags_valid), 64'(fl && t == p));
      if (t == l)
        chk(res_lo == e[31:0], "R2", $sformatf("lo word op%0d", op), 64'(res_lo), 64'(e[31:0]));
      if (lng && t == l + 1)
        chk(res_hi == e[63:32], "R2", $sformatf("hi word op%0d", op), 64'(res_hi), 64'(e[63:32]));
      if (fl && t == p) begin
        chk(flag_n == (lng ? e[63] : e[31]), "R9", $sformatf("N op%0d", op),
            64'(flag_n), 64'(lng ? e[63] : e[31]));
        chk(flag_z == (lng ? (e == 0) : (e[31:0] == 0)), "R9", $sformatf("Z op%0d", op),
            64'(flag_z), 64'(lng ? (e == 0) : (e[31:0] == 0)));
      end
      @(negedge clk);
    end
  endtask

  task automatic test_reserved();
    @(negedge clk);
    start = 1'b1; op_code = 4'd12; src_a = 32'd7; src_b = 32'd9; set_flags = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int t = 0; t < 6; t++) begin
      chk(!busy, "R11", "busy on reserved code", 64'(busy), 64'd0);
      chk(!res_lo_valid && !res_hi_valid && !flags_valid, "R11", "strobe on reserved code",
          {61'd0, res_lo_valid, res_hi_valid, flags_valid}, 64'd0);
      @(negedge clk);
    end
  endtask

  task automatic test_back_to_back();
    logic [63:0] e1, e2;
    e1 = ref_val(6, 32'hDEAD_BEEF, 32'h1234_5678, 64'd0);
    e2 = ref_val(0, 32'h0000_FFFE, 32'h0000_0007, 64'd0);
    @(negedge clk);
    start = 1'b1; op_code = 4'd6; src_a = 32'hDEAD_BEEF; src_b = 32'h1234_5678; set_flags = 1'b0;
    @(negedge clk);
    start = 1'b0;
    for (int t = 0; t < 9; t++) begin
      if (t == 3) begin
        start = 1'b1; op_code = 4'd0; src_a = 32'h0000_FFFE; src_b = 32'h0000_0007;
      end
      if (t == 4) start = 1'b0;
      if (t == 3) chk(!busy, "R12", "busy free before restart", 64'(busy), 64'd0);
      if (t == 4) begin
        chk(busy, "R12", "second op accepted", 64'(busy), 64'd1);
        chk(res_lo_valid && res_lo == e1[31:0], "R12", "first lo word",
            64'(res_lo), 64'(e1[31:0]));
      end
      if (t == 5)
        chk(res_hi_valid && res_hi == e1[63:32], "R12", "first hi word",
            64'(res_hi), 64'(e1[63:32]));
      if (t == 6)
        chk(res_lo_valid && res_lo == e2[31:0], "R12", "second lo word",
            64'(res_lo), 64'(e2[31:0]));
      if (t == 7 || t == 8)
        chk(!res_lo_valid && !res_hi_valid, "R12", "no stray strobe",
            {62'd0, res_lo_valid, res_hi_valid}, 64'd0);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !res_lo_valid && !res_hi_valid && !flags_valid, "R1", "outputs in reset",
        {60'd0, busy, res_lo_valid, res_hi_valid, flags_valid}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !res_lo_valid && !res_hi_valid && !flags_valid, "R1", "outputs after reset",
        {60'd0, busy, res_lo_valid, res_hi_valid, flags_valid}, 64'd0);

    // R4 16-bit classes, signed extremes; set-flags ignored on them (R9)
    run_op(0, 32'h0000_8000, 32'hFFFF_8000, 64'd0, 1'b0, 1'b0);
    run_op(0, 32'h1234_7FFF, 32'h0000_8000, 64'd0, 1'b1, 1'b0);
    run_op(1, 32'h8000_0000, 32'h0000_8000, 64'd0, 1'b0, 1'b0);
    run_op(1, 32'h7FFF_FFFF, 32'h1234_7FFF, 64'd0, 1'b1, 1'b0);
    run_op(2, 32'h0000_FFFF, 32'h0000_0002, 64'h5, 1'b0, 1'b0);
    run_op(3, 32'h1234_5678, 32'h0000_ABCD, 64'hFFFF_FFFF_F000_0000, 1'b1, 1'b0);
    // R5 / R6 32x32 forms
    run_op(4, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 64'd0, 1'b0, 1'b0);
    run_op(4, 32'h8000_0000, 32'h0000_0002, 64'd0, 1'b1, 1'b0);
    run_op(4, 32'h0000_0003, 32'hFFFF_FFFF, 64'd0, 1'b1, 1'b0);
    run_op(5, 32'h0001_0001, 32'h0001_0001, 64'h0000_0000_8000_0000, 1'b0, 1'b0);
    run_op(5, 32'h0000_0005, 32'h0000_0007, 64'hFFFF_FFFF_FFFF_FFDD, 1'b1, 1'b0);
    // R7 / R8 long forms
    run_op(6, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 64'd0, 1'b0, 1'b0);
    run_op(6, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 64'd0, 1'b1, 1'b0);
    run_op(7, 32'h8000_0000, 32'h8000_0000, 64'd0, 1'b1, 1'b0);
    run_op(7, 32'hFFFF_FFFF, 32'h0000_0001, 64'd0, 1'b0, 1'b0);
    run_op(8, 32'h8765_4321, 32'hF0F0_F0F0, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 1'b0);
    run_op(9, 32'h0000_0005, 32'h0000_0007, 64'hFFFF_FFFF_FFFF_FFDD, 1'b1, 1'b0);
    run_op(9, 32'h8000_0000, 32'h7FFF_FFFF, 64'h0123_4567_89AB_CDEF, 1'b0, 1'b0);
    // R10 start during busy
    run_op(4, 32'h0000_1234, 32'h0000_0100, 64'd0, 1'b1, 1'b1);
    run_op(7, 32'hFFFF_FFFE, 32'h0000_0003, 64'd0, 1'b1, 1'b1);
    test_reserved();
    test_back_to_back();

    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

endmodule